// File: doc/BRIEF.md
# Switch Forwarding Mask Resolver

The resolver takes the lookup results for one received frame and turns them into the final set of egress ports, or a decision to drop the frame. It sits after the address table and VLAN lookup of a multi-port switch and before the queue manager. The default configuration serves 28 ports: 27 network ports and one management port. Every input belongs to a single request qualified by `in_valid`. The result appears on registered outputs one clock later, qualified by `out_valid`.

The block screens the frame first. An unknown VLAN, a source that is not in the VLAN, or a secure address that appears on the wrong port makes it drop the frame. If the frame passes, it builds a starting mask from the destination lookup. It then widens that mask for frames from unknown sources. Next it removes the ports that may not transmit and the arrival port. Last, it adds the uplink port when mirroring applies. A load-sharing request goes out only as a trunk-adjust flag, because trunk hashing is not part of this block.

Top module: `fwd_mask_resolver`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high. While `in_valid` is low, the other outputs keep their last values. Synchronous reset clears every output to 0.
- R2: A request with `vlan_known`=0 produces `ev_unk_vlan`=1, `out_discard`=1 and an all-zero mask.
- R3: A request whose source port bit (bit index = `src_port`) is 0 in `vlan_members` produces `out_discard`=1 and an all-zero mask.
- R4: A request with `src_found`, `src_secure` and `src_moved` all 1 produces `ev_sec_viol`=1 and `out_discard`=1.
- R5: The starting mask is `vlan_members` when `dst_multicast`=1 or `dst_found`=0. Otherwise it is `dst_mask`.
- R6: When `src_found`=0, `unk_src_mask & vlan_members` is ORed into the mask.
- R7: After R5 and R6, the bits set in `disabled_mask` or `tx_block_mask` are cleared, and so is the source port bit.
- R8: The uplink bit is added when `mirror_en`=1, the source port is not the uplink port, the uplink port is neither disabled nor tx-blocked, and either the source is the mirror port or the mask left by R7 contains the mirror port.
- R9: `out_trunk_adj` equals `lshare_en` when the frame is kept and is 0 when it is discarded.
- R10: A discarded frame always has an all-zero mask. The discard decision takes priority over every mask rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_port | input | PW | Arrival port number |
| vlan_known | input | 1 | VLAN lookup hit |
| vlan_members | input | NP | Member ports of the VLAN |
| dst_found | input | 1 | Destination address hit |
| dst_multicast | input | 1 | Destination is a group address |
| dst_mask | input | NP | Ports of a found destination |
| src_found | input | 1 | Source address hit |
| src_secure | input | 1 | Found source entry is secured |
| src_moved | input | 1 | Found source entry lists another port |
| unk_src_mask | input | NP | Extra ports for unknown-source frames |
| disabled_mask | input | NP | Disabled ports |
| tx_block_mask | input | NP | Transmit-blocked ports |
| mirror_en | input | 1 | Mirroring enable |
| mirror_port | input | PW | Port being mirrored |
| uplink_port | input | PW | Mirror destination port |
| lshare_en | input | 1 | Load-sharing enable |
| out_valid | output | 1 | Result strobe |
| out_mask | output | NP | Final egress port mask |
| out_discard | output | 1 | Frame is dropped |
| ev_unk_vlan | output | 1 | Unknown-VLAN event |
| ev_sec_viol | output | 1 | Security-violation event |
| out_trunk_adj | output | 1 | Mask to be adjusted by trunking |

## Verification
A six-port build is swept with several thousand pseudo-random requests. The generator biases the flags so that every screen path and every mask path occurs many times. The sweep covers known unicast against multicast and unknown destinations, which separates the two starting masks. It covers known against unknown sources, which exposes the widening step. Disabled, tx-blocked and source ports that overlap the mask test the removal step. Mirror and uplink choices that coincide with the source, with each other and with blocked ports separate the mirroring conditions. Directed cases pin the uplink-is-source exclusion, the screen priorities and output holding between requests.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef struct packed {
    logic discard;
    logic unk_vlan;
    logic sec_viol;
  } fwd_verdict_t;
endpackage

// File: rtl/fwd_screen.sv
module fwd_screen #(
  parameter int NP = 28,
  localparam int PW = $clog2(NP)
) (
  input  logic [PW-1:0]        src_port,
  input  logic                 vlan_known,
  input  logic [NP-1:0]        vlan_members,
  input  logic                 src_found,
  input  logic                 src_secure,
  input  logic                 src_moved,
  output fwd_pkg::fwd_verdict_t verdict
);
  logic is_member;
  logic sec_hit;

  assign is_member = vlan_members[src_port];
  assign sec_hit   = src_found & src_secure & src_moved;

  always_comb begin
    verdict.unk_vlan = ~vlan_known;
    verdict.sec_viol = sec_hit;
    verdict.discard  = ~vlan_known | ~is_member | sec_hit;
  end
endmodule

// File: rtl/fwd_base_mask.sv
module fwd_base_mask #(
  parameter int NP = 28,
  localparam int PW = $clog2(NP)
) (
  input  logic [PW-1:0] src_port,
  input  logic [NP-1:0] vlan_members,
  input  logic          dst_found,
  input  logic          dst_multicast,
  input  logic [NP-1:0] dst_mask,
  input  logic          src_found,
  input  logic [NP-1:0] unk_src_mask,
  input  logic [NP-1:0] stop_mask,
  output logic [NP-1:0] code
);
  logic [NP-1:0] src_oh;
  logic [NP-1:0] start;
  logic [NP-1:0] widened;

  for (genvar g = 0; g < NP; g++) begin : g_src
    assign src_oh[g] = (src_port == PW'(g));
  end

  assign start   = (dst_multicast | ~dst_found) ? vlan_members : dst_mask;
  assign widened = src_found ? start : (start | (unk_src_mask & vlan_members));
  assign code    = widened & ~stop_mask & ~src_oh;
endmodule

// File: rtl/fwd_mirror.sv
module fwd_mirror #(
  parameter int NP = 28,
  localparam int PW = $clog2(NP)
) (
  input  logic [NP-1:0] code_in,
  input  logic [PW-1:0] src_port,
  input  logic          mirror_en,
  input  logic [PW-1:0] mirror_port,
  input  logic [PW-1:0] uplink_port,
  input  logic [NP-1:0] stop_mask,
  output logic [NP-1:0] code_out
);
  logic [NP-1:0] up_oh;
  logic          hit;
  logic          up_ok;

  for (genvar g = 0; g < NP; g++) begin : g_up
    assign up_oh[g] = (uplink_port == PW'(g));
  end

  assign hit      = (src_port == mirror_port) | code_in[mirror_port];
  assign up_ok    = (src_port != uplink_port) & ~stop_mask[uplink_port];
  assign code_out = (mirror_en & hit & up_ok) ? (code_in | up_oh) : code_in;
endmodule

// File: rtl/fwd_mask_resolver.sv
module fwd_mask_resolver #(
  parameter int NP = 28,
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [PW-1:0] src_port,
  input  logic          vlan_known,
  input  logic [NP-1:0] vlan_members,
  input  logic          dst_found,
  input  logic          dst_multicast,
  input  logic [NP-1:0] dst_mask,
  input  logic          src_found,
  input  logic          src_secure,
  input  logic          src_moved,
  input  logic [NP-1:0] unk_src_mask,
  input  logic [NP-1:0] disabled_mask,
  input  logic [NP-1:0] tx_block_mask,
  input  logic          mirror_en,
  input  logic [PW-1:0] mirror_port,
  input  logic [PW-1:0] uplink_port,
  input  logic          lshare_en,
  output logic          out_valid,
  output logic [NP-1:0] out_mask,
  output logic          out_discard,
  output logic          ev_unk_vlan,
  output logic          ev_sec_viol,
  output logic          out_trunk_adj
);
  fwd_pkg::fwd_verdict_t verdict;
  logic [NP-1:0] stop_mask;
  logic [NP-1:0] base_code;
  logic [NP-1:0] mir_code;
  logic [PW-1:0] src_q;

  assign stop_mask = disabled_mask | tx_block_mask;

  fwd_screen #(.NP(NP)) u_screen (
    .src_port(src_port), .vlan_known(vlan_known), .vlan_members(vlan_members),
    .src_found(src_found), .src_secure(src_secure), .src_moved(src_moved),
    .verdict(verdict)
  );

  fwd_base_mask #(.NP(NP)) u_base (
    .src_port(src_port), .vlan_members(vlan_members), .dst_found(dst_found),
    .dst_multicast(dst_multicast), .dst_mask(dst_mask), .src_found(src_found),
    .unk_src_mask(unk_src_mask), .stop_mask(stop_mask), .code(base_code)
  );

  fwd_mirror #(.NP(NP)) u_mirror (
    .code_in(base_code), .src_port(src_port), .mirror_en(mirror_en),
    .mirror_port(mirror_port), .uplink_port(uplink_port), .stop_mask(stop_mask),
    .code_out(mir_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_mask      <= '0;
      out_discard   <= 1'b0;
      ev_unk_vlan   <= 1'b0;
      ev_sec_viol   <= 1'b0;
      out_trunk_adj <= 1'b0;
      src_q         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask      <= verdict.discard ? '0 : mir_code;
        out_discard   <= verdict.discard;
        ev_unk_vlan   <= verdict.unk_vlan;
        ev_sec_viol   <= verdict.sec_viol;
        out_trunk_adj <= lshare_en & ~verdict.discard;
        src_q         <= src_port;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));
  p_unk_vlan_drop_r2: assert property (@(posedge clk) disable iff (rst)
    ev_unk_vlan |-> out_discard);
  p_sec_drop_r4: assert property (@(posedge clk) disable iff (rst)
    ev_sec_viol |-> out_discard);
  p_no_stopped_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mask & $past(stop_mask)) == '0);
  p_no_src_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_mask[src_q]);
  p_drop_empty_r10: assert property (@(posedge clk) disable iff (rst)
    out_discard |-> (out_mask == '0 && !out_trunk_adj));
endmodule

// File: tb/sim_fwd_mask_resolver.sv
module sim_fwd_mask_resolver;
  localparam int NP = 6;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [PW-1:0] src_port = '0, mirror_port = '0, uplink_port = '0;
  logic vlan_known = 0, dst_found = 0, dst_multicast = 0, src_found = 0;
  logic src_secure = 0, src_moved = 0, mirror_en = 0, lshare_en = 0;
  logic [NP-1:0] vlan_members = '0, dst_mask = '0, unk_src_mask = '0;
  logic [NP-1:0] disabled_mask = '0, tx_block_mask = '0;
  logic out_valid, out_discard, ev_unk_vlan, ev_sec_viol, out_trunk_adj;
  logic [NP-1:0] out_mask;

  int checks = 0, errors = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #4 clk = ~clk;

  fwd_mask_resolver #(.NP(NP)) u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic fire_and_check();
    logic [NP-1:0] code, stop;
    logic disc, sec, hit;
    sec  = src_found & src_secure & src_moved;
    disc = !vlan_known | !vlan_members[src_port] | sec;
    stop = disabled_mask | tx_block_mask;
    code = (dst_multicast | !dst_found) ? vlan_members : dst_mask;  // R5
    if (!src_found) code |= unk_src_mask & vlan_members;           // R6
    code &= ~stop;                                                  // R7
    code[src_port] = 1'b0;
    hit = (src_port == mirror_port) | code[mirror_port];            // R8
    if (mirror_en && hit && src_port != uplink_port && !stop[uplink_port])
      code[uplink_port] = 1'b1;
    if (disc) code = '0;                                            // R10
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R1 valid", 32'(out_valid), 1);
    check("R2 unk_vlan", 32'(ev_unk_vlan), 32'(!vlan_known));
    check("R4 sec_viol", 32'(ev_sec_viol), 32'(sec));
    check("R3/R10 discard", 32'(out_discard), 32'(disc));
    check("R8 mask", 32'(out_mask), 32'(code));
    check("R9 trunk", 32'(out_trunk_adj), 32'(lshare_en & !disc));
  endtask

  task automatic clean(logic [PW-1:0] s);
    src_port = s; vlan_known = 1; vlan_members = '1; dst_found = 1;
    dst_multicast = 0; dst_mask = '0; src_found = 1; src_secure = 0;
    src_moved = 0; unk_src_mask = '0; disabled_mask = '0; tx_block_mask = '0;
    mirror_en = 0; mirror_port = '0; uplink_port = '0; lshare_en = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(out_valid), 0);
    check("R1 reset mask", 32'(out_mask), 0);
    check("R1 reset flags", {out_discard, ev_unk_vlan, ev_sec_viol, out_trunk_adj}, 0);
    rst = 1'b0;

    // R8: source is uplink, mirror hit via source -> no uplink bit
    clean(3); mirror_en = 1; mirror_port = 3; uplink_port = 3; dst_mask = 6'b000010;
    fire_and_check();
    check("R8 uplink excluded", 32'(out_mask), 32'h02);
    // R8: mirror port in mask -> uplink added
    clean(0); mirror_en = 1; mirror_port = 2; uplink_port = 5; dst_mask = 6'b000100;
    fire_and_check();
    check("R8 uplink added", 32'(out_mask), 32'h24);
    // R7: uplink tx-blocked -> not added
    tx_block_mask = 6'b100000; fire_and_check();
    check("R7 blocked uplink", 32'(out_mask), 32'h04);
    // R6 unknown source widening
    clean(1); src_found = 0; vlan_members = 6'b011011; unk_src_mask = 6'b111000;
    dst_mask = 6'b000001; fire_and_check();
    check("R6 widen", 32'(out_mask), 32'h19);
    // R5 multicast starts from members minus source
    clean(4); dst_multicast = 1; vlan_members = 6'b110001; fire_and_check();
    check("R5 multicast", 32'(out_mask), 32'h21);
    // R3 non-member source
    clean(2); vlan_members = 6'b111011; dst_mask = 6'b000001; lshare_en = 1;
    fire_and_check();
    check("R3 non-member", 32'(out_discard), 1);
    // R1 hold: idle cycles keep previous outputs
    clean(0); dst_mask = 6'b111110;
    @(negedge clk); @(negedge clk);
    check("R1 hold", 32'(out_discard), 1);

    for (int i = 0; i < 4000; i++) begin
      step(); src_port = PW'(lfsr[7:0] % NP);
      vlan_known = lfsr[10:8] != 0;
      step(); vlan_members = NP'(lfsr) | (lfsr[30] ? NP'(0) : (NP'(1) << src_port));
      dst_found = lfsr[12]; dst_multicast = lfsr[13] & lfsr[14];
      step(); dst_mask = lfsr[20] ? NP'(lfsr) : (NP'(1) << (lfsr[3:0] % NP));
      src_found = lfsr[22]; src_secure = lfsr[23]; src_moved = lfsr[24] & lfsr[25];
      step(); unk_src_mask = NP'(lfsr);
      disabled_mask = NP'(lfsr >> 8) & NP'(lfsr >> 16);
      tx_block_mask = NP'(lfsr >> 12) & NP'(lfsr >> 20);
      step(); mirror_en = lfsr[0] | lfsr[1];
      mirror_port = PW'(lfsr[11:4] % NP); uplink_port = PW'(lfsr[19:12] % NP);
      lshare_en = lfsr[27];
      fire_and_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule